// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block holds the software-visible control and fault-reporting state of an ECC memory controller. A simple word-wide bus selects one of nine 32-bit registers by word index. The registers are: enable, delay, fault status, video configuration, two fault address words, a diagnostic word and two event counters. A second select on the same bus reaches a four-byte scratch window that takes single-byte accesses. The ECC datapath reports a detected fault on a one-cycle strobe. That strobe loads the status word and both address words, and it raises a level interrupt. Software clears the interrupt by writing the fault status register.

A build-time parameter picks one of three controller variants. The variant sets which enable bits are writable and which enable bits survive a reset. It also decides whether the enable register shows a hardwired identity code and whether the byte window exists at all. Read data is registered and appears one cycle after the accepted read. Every cycle that carries no accepted read returns zero.

Top module: `ecc_ctl_regs`

## Requirements
- R1: The word index is bus_addr[ADDR_W-1:2]. Index 3 (video configuration), 6 (diagnostic word), 7 (event counter A) and 8 (event counter B) are independent 32-bit storage, and each reads back exactly what was last written to it.
- R2: The word window acts only on bus_size = 2 (4 bytes; encoding 0 = byte, 1 = half, 2 = word, 3 = reserved). A word-window access of any other size changes nothing and reads zero.
- R3: A write to index 0 stores data & 0x103 for variant 0 and data & 0xBFF for variants 1 and 2. For variants 1 and 2, reads of index 0 carry the variant number in bits [31:28] and the VERSION parameter in bits [27:24]. For variant 0 these bits read zero.
- R4: A write to index 1 stores data & 0x7FFFFFFF, so bit 31 of the delay register always reads zero.
- R5: Any word write to index 2 stores the written value and drives irq low from the next cycle.
- R6: A fault strobe loads the fault status word (index 2), fault address 0 (index 4) and fault address 1 (index 5) from its inputs and drives irq high from the next cycle. It wins over a bus write to index 2 in the same cycle.
- R7: Indices 4 and 5 are read-only. Bus writes to them are ignored.
- R8: After reset: delay = 0x00000020, fault address 0 = 0x07C00000, all other registers of indices 1 to 8 = 0, and irq is low.
- R9: Reset clears the enable register except bit 8 (variant 0) or bits [9:2] and bit 11 (variants 1 and 2). The kept bits hold their values through reset.
- R10: For variant 0, a diag_sel access with bus_size = 0 reaches byte bus_addr[1:0] of a 4-byte window, and a read returns that byte in bus_rdata[7:0]. Window accesses of any other size change nothing and read zero.
- R11: For variants 1 and 2, the byte window does not exist: its reads return zero and its writes have no effect.
- R12: Word indices 9 and above read zero, and writes to them change no register.
- R13: bus_rdata is valid in the cycle after an accepted read and is zero after any cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| main_sel | input | 1 | Access to the word register window this cycle |
| diag_sel | input | 1 | Access to the byte window this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address within the selected window |
| bus_wdata | input | 32 | Write data (byte window uses bits [7:0]) |
| bus_rdata | output | 32 | Registered read data |
| flt_log | input | 1 | One-cycle fault report strobe |
| flt_status | input | 32 | Fault status value to capture |
| flt_addr0 | input | 32 | First fault address word to capture |
| flt_addr1 | input | 32 | Second fault address word to capture |
| irq | output | 1 | Fault interrupt level |

## Verification
The hardest state to reach from the ports is the enable register's partial survival across reset. The kept bits must first hold a value that differs from their cleared value, then a reset must arrive, and then they must be read back alongside bits that were cleared. The stimulus writes all-ones to the enable register and pulses reset. It also fires resets at random points within a seeded random stream of word and byte accesses, so that reset lands on many different enable contents. Three instances of the bank, one per variant, see identical stimulus, so one access checks all the masks that depend on the variant. Fault strobes are timed onto the same cycle as status writes to exercise the interrupt priority.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 9;
  localparam int DIAG_BYTES = 4;

  // word indices; software depends on this order
  localparam int IDX_ENABLE = 0;
  localparam int IDX_DELAY  = 1;
  localparam int IDX_FSTAT  = 2;
  localparam int IDX_VCFG   = 3;
  localparam int IDX_FADDR0 = 4;
  localparam int IDX_FADDR1 = 5;
  localparam int IDX_DIAGW  = 6;
  localparam int IDX_EVCA   = 7;
  localparam int IDX_EVCB   = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [DATA_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
  localparam logic [DATA_W-1:0] DELAY_RST   = 32'h0000_0020;
  localparam logic [DATA_W-1:0] FADDR0_RST  = 32'h07C0_0000;

  function automatic logic [DATA_W-1:0] enable_wmask(int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [DATA_W-1:0] enable_keep(int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'h0000_0BFC;
  endfunction

  function automatic logic [DATA_W-1:0] enable_ident(int variant, logic [3:0] version);
    return (variant == 0) ? '0 : {4'(variant), version, 24'h0};
  endfunction

endpackage

// File: rtl/ecc_regs_decode.sv
module ecc_regs_decode
  import ecc_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic                main_sel,
  input  logic                bus_we,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic                rd_hit,
  output logic [IDX_W-1:0]    rd_idx
);

  logic [IDX_W-1:0] idx;
  logic             word_ok;
  logic             mapped;
  wire  [1:0]       unused_lsb = bus_addr[1:0];

  assign idx     = bus_addr[ADDR_W-1:2];
  assign word_ok = main_sel && (acc_size_e'(bus_size) == SZ_WORD);
  assign mapped  = (idx < IDX_W'(NUM_REGS));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_strobe
    assign wr_hit[r] = word_ok && bus_we && mapped && (idx == IDX_W'(r));
  end

  assign rd_hit = word_ok && !bus_we && mapped;
  assign rd_idx = idx;

endmodule

// File: rtl/ecc_regs_enable.sv
module ecc_regs_enable
  import ecc_regs_pkg::*;
#(
  parameter int         VARIANT = 1,
  parameter logic [3:0] VERSION = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] value
);

  localparam logic [DATA_W-1:0] WMASK = enable_wmask(VARIANT);
  localparam logic [DATA_W-1:0] KEEP  = enable_keep(VARIANT);
  localparam logic [DATA_W-1:0] IDENT = enable_ident(VARIANT, VERSION);

  logic [DATA_W-1:0] stored;

  // each bit picks its flop flavour: kept through reset, cleared, or absent
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (KEEP[b]) begin : g_keep
      logic q;
      always_ff @(posedge clk) begin
        if (wr_en) q <= wr_data[b];
      end
      assign stored[b] = q;
    end else if (WMASK[b]) begin : g_clr
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_en) q <= wr_data[b];
      end
      assign stored[b] = q;
    end else begin : g_none
      wire unused_bit = wr_data[b];
      assign stored[b] = 1'b0;
    end
  end

  assign value = stored | IDENT;

endmodule

// File: rtl/ecc_regs_diag.sv
module ecc_regs_diag
  import ecc_regs_pkg::*;
#(
  parameter bit PRESENT = 1'b1,
  localparam int SEL_W = $clog2(DIAG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             diag_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_size,
  input  logic [SEL_W-1:0] byte_sel,
  input  logic [7:0]       wr_byte,
  output logic             rd_hit,
  output logic [7:0]       rd_byte
);

  if (PRESENT) begin : g_win
    logic       byte_ok;
    logic [7:0] mem_q [DIAG_BYTES];
    logic [7:0] mem_d [DIAG_BYTES];

    assign byte_ok = diag_sel && (acc_size_e'(bus_size) == SZ_BYTE);

    always_comb begin
      mem_d = mem_q;
      if (byte_ok && bus_we) mem_d[byte_sel] = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DIAG_BYTES; i++) mem_q[i] <= 8'h00;
      end else begin
        mem_q <= mem_d;
      end
    end

    assign rd_hit  = byte_ok && !bus_we;
    assign rd_byte = mem_q[byte_sel];
  end else begin : g_absent
    wire unused_win = ^{clk, rst_n, diag_sel, bus_we, bus_size, byte_sel, wr_byte};
    assign rd_hit  = 1'b0;
    assign rd_byte = 8'h00;
  end

endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
  import ecc_regs_pkg::*;
#(
  parameter int         VARIANT = 1,
  parameter logic [3:0] VERSION = 4'h0,
  parameter int         ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_sel,
  input  logic              diag_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_log,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr0,
  input  logic [31:0]       flt_addr1,
  output logic              irq
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int SEL_W    = $clog2(DIAG_BYTES);
  localparam bit HAS_DIAG = (VARIANT == 0);

  logic [NUM_REGS-1:0] wr_hit;
  logic                rd_hit;
  logic [IDX_W-1:0]    rd_idx;
  logic [DATA_W-1:0]   en_value;
  logic                diag_hit;
  logic [7:0]          diag_byte;

  logic [DATA_W-1:0] delay_q, delay_d;
  logic [DATA_W-1:0] fstat_q, fstat_d;
  logic [DATA_W-1:0] vcfg_q, vcfg_d;
  logic [DATA_W-1:0] faddr0_q, faddr0_d;
  logic [DATA_W-1:0] faddr1_q, faddr1_d;
  logic [DATA_W-1:0] diagw_q, diagw_d;
  logic [DATA_W-1:0] evca_q, evca_d;
  logic [DATA_W-1:0] evcb_q, evcb_d;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] word_mux;

  wire unused_ro = wr_hit[IDX_FADDR0] | wr_hit[IDX_FADDR1];

  ecc_regs_decode #(.ADDR_W(ADDR_W)) u_decode (
    .main_sel (main_sel),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .rd_idx   (rd_idx)
  );

  ecc_regs_enable #(.VARIANT(VARIANT), .VERSION(VERSION)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hit[IDX_ENABLE]),
    .wr_data (bus_wdata),
    .value   (en_value)
  );

  ecc_regs_diag #(.PRESENT(HAS_DIAG)) u_diag (
    .clk      (clk),
    .rst_n    (rst_n),
    .diag_sel (diag_sel),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .byte_sel (bus_addr[SEL_W-1:0]),
    .wr_byte  (bus_wdata[7:0]),
    .rd_hit   (diag_hit),
    .rd_byte  (diag_byte)
  );

  // next-state for the plain and fault registers
  always_comb begin
    delay_d  = delay_q;
    vcfg_d   = vcfg_q;
    diagw_d  = diagw_q;
    evca_d   = evca_q;
    evcb_d   = evcb_q;
    fstat_d  = fstat_q;
    faddr0_d = faddr0_q;
    faddr1_d = faddr1_q;
    irq_d    = irq_q;

    if (wr_hit[IDX_DELAY]) delay_d = bus_wdata & DELAY_WMASK;
    if (wr_hit[IDX_VCFG])  vcfg_d  = bus_wdata;
    if (wr_hit[IDX_DIAGW]) diagw_d = bus_wdata;
    if (wr_hit[IDX_EVCA])  evca_d  = bus_wdata;
    if (wr_hit[IDX_EVCB])  evcb_d  = bus_wdata;

    if (wr_hit[IDX_FSTAT]) begin
      fstat_d = bus_wdata;
      irq_d   = 1'b0;
    end

    // a fault report overrides a same-cycle software clear
    if (flt_log) begin
      fstat_d  = flt_status;
      faddr0_d = flt_addr0;
      faddr1_d = flt_addr1;
      irq_d    = 1'b1;
    end
  end

  // read path
  always_comb begin
    case (rd_idx)
      IDX_W'(IDX_ENABLE): word_mux = en_value;
      IDX_W'(IDX_DELAY):  word_mux = delay_q;
      IDX_W'(IDX_FSTAT):  word_mux = fstat_q;
      IDX_W'(IDX_VCFG):   word_mux = vcfg_q;
      IDX_W'(IDX_FADDR0): word_mux = faddr0_q;
      IDX_W'(IDX_FADDR1): word_mux = faddr1_q;
      IDX_W'(IDX_DIAGW):  word_mux = diagw_q;
      IDX_W'(IDX_EVCA):   word_mux = evca_q;
      IDX_W'(IDX_EVCB):   word_mux = evcb_q;
      default:            word_mux = '0;
    endcase

    if (rd_hit)        rdata_d = word_mux;
    else if (diag_hit) rdata_d = {{(DATA_W-8){1'b0}}, diag_byte};
    else               rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q  <= DELAY_RST;
      fstat_q  <= '0;
      vcfg_q   <= '0;
      faddr0_q <= FADDR0_RST;
      faddr1_q <= '0;
      diagw_q  <= '0;
      evca_q   <= '0;
      evcb_q   <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      delay_q  <= delay_d;
      fstat_q  <= fstat_d;
      vcfg_q   <= vcfg_d;
      faddr0_q <= faddr0_d;
      faddr1_q <= faddr1_d;
      diagw_q  <= diagw_d;
      evca_q   <= evca_d;
      evcb_q   <= evcb_d;
      irq_q    <= irq_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/ecc_regs_chk.sv
module ecc_regs_chk #(
  parameter int         VARIANT = 1,
  parameter logic [3:0] VERSION = 4'h0,
  parameter int         ADDR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              main_sel,
  input logic              diag_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              flt_log,
  input logic              irq
);

  localparam int         IDX_W    = ADDR_W - 2;
  localparam logic [7:0] IDENT_HI = (VARIANT == 0) ? 8'h00 : {4'(VARIANT), VERSION};
  localparam bit         NO_DIAG  = (VARIANT != 0);

  logic [IDX_W-1:0] idx;
  logic             word_rd;
  logic             word_wr;
  wire  [1:0]       unused_lo = bus_addr[1:0];

  assign idx     = bus_addr[ADDR_W-1:2];
  assign word_rd = main_sel && !bus_we && (bus_size == 2'd2);
  assign word_wr = main_sel &&  bus_we && (bus_size == 2'd2);

  assert_odd_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (main_sel && !diag_sel && bus_size != 2'd2) |=> (bus_rdata == 32'h0));

  assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && idx == IDX_W'(0)) |=> (bus_rdata[31:24] == IDENT_HI));

  assert_delay_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && idx == IDX_W'(1)) |=> !bus_rdata[31]);

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && idx == IDX_W'(2) && !flt_log) |=> !irq);

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_log |=> irq);

  assert_no_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (NO_DIAG && diag_sel && !main_sel) |=> (bus_rdata == 32'h0));

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && idx >= IDX_W'(9)) |=> (bus_rdata == 32'h0));

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_sel && !diag_sel) |=> (bus_rdata == 32'h0));

endmodule

bind ecc_ctl_regs ecc_regs_chk #(
  .VARIANT(VARIANT),
  .VERSION(VERSION),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .main_sel  (main_sel),
  .diag_sel  (diag_sel),
  .bus_we    (bus_we),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .flt_log   (flt_log),
  .irq       (irq)
);

// File: tb/ecc_ctl_regs_tb.sv
`timescale 1ns/1ps
module ecc_ctl_regs_tb;

  localparam logic [3:0] VER = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        main_sel, diag_sel, bus_we, flt_log;
  logic [1:0]  bus_size;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, flt_status, flt_addr0, flt_addr1;
  logic [31:0] rd [3];
  logic        irq_o [3];

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [31:0] m_reg  [3][9];
  logic [7:0]  m_diag [4];
  logic        m_irq  [3];

  always #2.5 clk = ~clk;

  ecc_ctl_regs #(.VARIANT(1), .VERSION(VER), .ADDR_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_sel(main_sel), .diag_sel(diag_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[1]),
    .flt_log(flt_log), .flt_status(flt_status), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
    .irq(irq_o[1]));

  ecc_ctl_regs #(.VARIANT(0), .VERSION(VER), .ADDR_W(6)) u_dut_v0 (
    .clk(clk), .rst_n(rst_n), .main_sel(main_sel), .diag_sel(diag_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[0]),
    .flt_log(flt_log), .flt_status(flt_status), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
    .irq(irq_o[0]));

  ecc_ctl_regs #(.VARIANT(2), .VERSION(VER), .ADDR_W(6)) u_dut_v2 (
    .clk(clk), .rst_n(rst_n), .main_sel(main_sel), .diag_sel(diag_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[2]),
    .flt_log(flt_log), .flt_status(flt_status), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
    .irq(irq_o[2]));

  // ---------------- reference model, built from the requirements ----------------
  function automatic logic [31:0] m_ident(int v);
    return (v == 0) ? 32'h0 : {4'(v), VER, 24'h0};
  endfunction

  function automatic logic [31:0] m_keep(int v);
    return (v == 0) ? 32'h100 : 32'hBFC;
  endfunction

  function automatic logic [31:0] m_read(int v, int idx);
    if (idx == 0) return m_ident(v) | m_reg[v][0];
    if (idx >= 9) return 32'h0;
    return m_reg[v][idx];
  endfunction

  task automatic m_reset();
    for (int v = 0; v < 3; v++) begin
      m_reg[v][0] = m_reg[v][0] & m_keep(v);
      m_reg[v][1] = 32'h20;
      m_reg[v][4] = 32'h07C0_0000;
      m_reg[v][2] = 0; m_reg[v][3] = 0; m_reg[v][5] = 0;
      m_reg[v][6] = 0; m_reg[v][7] = 0; m_reg[v][8] = 0;
      m_irq[v] = 1'b0;
    end
    for (int i = 0; i < 4; i++) m_diag[i] = 8'h00;
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp, input logic [31:0] mask);
    vectors++;
    if (((act ^ exp) & mask) != 32'h0) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (mask %h)", tag, what, act, exp, mask);
    end
  endtask

  task automatic idle();
    main_sel = 0; diag_sel = 0; bus_we = 0; bus_size = 2'd2; bus_addr = 0;
    bus_wdata = 0; flt_log = 0; flt_status = 0; flt_addr0 = 0; flt_addr1 = 0;
  endtask

  // one bus cycle: drive at a falling edge, check at the next falling edge
  task automatic op(input bit ms, input bit ds, input bit we, input logic [1:0] sz,
                    input logic [5:0] addr, input logic [31:0] wd, input bit fl,
                    input logic [31:0] fs, input logic [31:0] fa0, input logic [31:0] fa1,
                    input string tag, input logic [31:0] cmask = 32'hFFFF_FFFF);
    logic [31:0] exp_rd [3];
    int idx;
    idx = int'(addr[5:2]);
    for (int v = 0; v < 3; v++) begin
      exp_rd[v] = 32'h0;
      if (ms && !we && sz == 2'd2) exp_rd[v] = m_read(v, idx);
      else if (!ms && ds && !we && sz == 2'd0 && v == 0) exp_rd[v] = {24'h0, m_diag[addr[1:0]]};
    end
    main_sel = ms; diag_sel = ds; bus_we = we; bus_size = sz; bus_addr = addr;
    bus_wdata = wd; flt_log = fl; flt_status = fs; flt_addr0 = fa0; flt_addr1 = fa1;
    @(posedge clk);
    @(negedge clk);
    idle();
    for (int v = 0; v < 3; v++) begin
      if (ms && we && sz == 2'd2) begin
        case (idx)
          0: m_reg[v][0] = wd & ((v == 0) ? 32'h103 : 32'hBFF);
          1: m_reg[v][1] = wd & 32'h7FFF_FFFF;
          2: begin m_reg[v][2] = wd; m_irq[v] = 1'b0; end
          3, 6, 7, 8: m_reg[v][idx] = wd;
          default: ;
        endcase
      end
      if (!ms && ds && we && sz == 2'd0 && v == 0) m_diag[addr[1:0]] = wd[7:0];
      if (fl) begin
        m_reg[v][2] = fs; m_reg[v][4] = fa0; m_reg[v][5] = fa1; m_irq[v] = 1'b1;
      end
      cmp(tag, $sformatf("rdata v%0d", v), rd[v], exp_rd[v], cmask);
      cmp(tag, $sformatf("irq v%0d", v), {31'h0, irq_o[v]}, {31'h0, m_irq[v]}, 32'h1);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input string tag);
    op(1, 0, 1, 2'd2, 6'(idx * 4), d, 0, 0, 0, 0, tag);
  endtask

  task automatic rdw(input int idx, input string tag);
    op(1, 0, 0, 2'd2, 6'(idx * 4), 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reset();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7713));
    idle();
    rst_n = 0;
    for (int v = 0; v < 3; v++) m_reg[v][0] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
    @(negedge clk);

    // R8: reset values; enable bits kept through reset are not yet defined
    for (int i = 1; i < 9; i++) rdw(i, "R8");
    op(1, 0, 0, 2'd2, 6'd0, 0, 0, 0, 0, 0, "R8", ~32'h0000_0BFC);

    // R3: write masks and identity code
    wr(0, 32'h0, "R3");            rdw(0, "R3");
    wr(0, 32'hFFFF_FFFF, "R3");    rdw(0, "R3");
    wr(0, 32'h5A5A_A5A5, "R3");    rdw(0, "R3");

    // R4: delay top bit never sticks
    wr(1, 32'hFFFF_FFFF, "R4");    rdw(1, "R4");

    // R6: fault capture raises irq
    op(0, 0, 0, 2'd2, 0, 0, 1, 32'h0001_2345, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R6");
    rdw(2, "R6"); rdw(4, "R6"); rdw(5, "R6");

    // R7: address words ignore bus writes
    wr(4, 32'h1111_1111, "R7"); wr(5, 32'h2222_2222, "R7");
    rdw(4, "R7"); rdw(5, "R7");

    // R5: status write clears irq
    wr(2, 32'h0000_00F0, "R5");    rdw(2, "R5");

    // R6: fault and clear in the same cycle, fault wins
    op(1, 0, 1, 2'd2, 6'd8, 32'h3333_3333, 1, 32'h0000_0008, 32'h4, 32'h5, "R6");
    rdw(2, "R6");

    // R1: independent plain registers, counter B is its own storage
    wr(3, 32'hC0FF_EE00, "R1"); wr(6, 32'h1234_5678, "R1");
    wr(7, 32'hAAAA_0007, "R1"); wr(8, 32'h5555_0008, "R1");
    rdw(7, "R1"); rdw(8, "R1"); rdw(3, "R1"); rdw(6, "R1");

    // R2: non-word sizes on the word window are ignored and read zero
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        op(1, 0, 1, 2'(s), 6'd12, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2");
        op(1, 0, 0, 2'(s), 6'd12, 0, 0, 0, 0, 0, "R2");
      end
    end
    rdw(3, "R2");

    // R12: unmapped indices
    for (int i = 9; i < 16; i++) begin
      wr(i, 32'hFFFF_FFFF, "R12");
      rdw(i, "R12");
    end
    for (int i = 0; i < 9; i++) rdw(i, "R12");

    // R10 / R11: byte window
    for (int b = 0; b < 4; b++) op(0, 1, 1, 2'd0, 6'(b), 32'(8'h10 + b * 8'h21), 0, 0, 0, 0, "R10");
    op(0, 1, 1, 2'd2, 6'd1, 32'hFF, 0, 0, 0, 0, "R10");
    for (int b = 0; b < 4; b++) op(0, 1, 0, 2'd0, 6'(b), 0, 0, 0, 0, 0, "R10/R11");
    op(0, 1, 0, 2'd1, 6'd2, 0, 0, 0, 0, 0, "R10");

    // R13: cycle without a read returns zero
    op(0, 0, 0, 2'd2, 0, 0, 0, 0, 0, 0, "R13");

    // R9: enable retention across reset
    wr(0, 32'hFFFF_FFFF, "R9");
    op(0, 0, 0, 2'd2, 0, 0, 1, 32'h9, 32'h1, 32'h2, "R9");
    do_reset();
    rdw(0, "R9"); rdw(1, "R8"); rdw(2, "R8"); rdw(4, "R8");
    op(0, 1, 0, 2'd0, 6'd1, 0, 0, 0, 0, 0, "R8");

    // random traffic with occasional resets
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      bit ms, ds, we, fl;
      logic [1:0] sz;
      logic [5:0] ad;
      r  = $urandom;
      ms = (r[2:0] != 3'd0);
      ds = !ms;
      we = r[3];
      fl = (r[7:4] == 4'd0);
      if (ms) begin
        sz = (r[10:8] == 3'd0) ? 2'(r[12:11]) : 2'd2;
        ad = 6'($urandom % 48);
      end else begin
        sz = (r[10:8] < 3'd6) ? 2'd0 : 2'(r[12:11]);
        ad = 6'($urandom);
      end
      op(ms, ds, we, sz, ad, $urandom, fl, $urandom, $urandom, $urandom, "R1");
      if ($urandom % 150 == 0) do_reset();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule